// File: doc/BRIEF.md
# Load/Store-Multiple Micro-Op Sequencer

The block takes one 32-bit block-transfer instruction, either a multi-register load or a multi-register store, and breaks it into a stream of micro-op descriptors. It emits one descriptor per accepted cycle over a valid/ready handshake. The stream opens with a copy of the base register. A single-register transfer follows for each set bit of the 16-bit register list, each carrying a register index and a signed byte offset from the base. When writeback is requested, a closing base-update micro-op comes last, given as a fully encoded 32-bit word. The final descriptor of every stream is flagged.

The instruction fields are fixed:
- register list in bits 15:0
- base register Rn in bits 19:16
- L (load) in bit 20
- W (writeback) in bit 21
- S in bit 22
- U (up) in bit 23
- P (pre-index) in bit 24
- condition in bits 31:28

The five-bit mode value is {P,U,S,W,L}, which is bits 24:20. An upstream decoder presents one instruction at a time. A downstream issue stage consumes the descriptors.

Top module: `lsm_uop_seq`

## Requirements
- R1: A new instruction is accepted (`inReady` high) only while no descriptor is pending. An accepted instruction with a valid mode produces exactly n+1+W descriptors, where n is the number of set bits in bits 15:0. The descriptors appear from the cycle after acceptance onwards.
- R2: The first descriptor has kind 0 (base copy). Its `outWord` equals the instruction's bits 31:16, with bits 15:0 zero.
- R3: Transfer descriptors have kind 1. They name the set register-list bits in ascending index order on `outReg`, and `outIsLoad` equals bit 20.
- R4: The first transfer offset depends on the mode. For modes 0x01 and 0x03 it is 4n-4. For 0x08, 0x09 and 0x0B it is 0. For 0x11 and 0x12 it is 4n. For 0x18 and 0x19 it is 4.
- R5: Each later transfer offset is the previous one plus 4 when U (bit 23) is 1, and minus 4 when U is 0. Offsets are two's complement on 32 bits.
- R6: When W is set, the last descriptor is a writeback. Its kind is 2 (add) when U=1 and 3 (subtract) when U=0. Its `outWord` is cond<<28 | 0x02400000 | Rn<<16 | Rn<<12 | 4n.
- R7: `outLast` is high on the final descriptor only. This holds for an empty register list as well, where the final descriptor is the base copy, or the writeback if W is set.
- R8: Mode values other than 0x01, 0x03, 0x08, 0x09, 0x0B, 0x11, 0x12, 0x18 and 0x19 are consumed without any descriptor. They raise `badMode` for exactly the cycle after acceptance.
- R9: While `outValid` is high and `outReady` is low, all descriptor outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction offered |
| inWord | input | 32 | Instruction word |
| inReady | output | 1 | Sequencer idle, instruction taken |
| outValid | output | 1 | Descriptor valid |
| outReady | input | 1 | Descriptor consumed |
| outKind | output | 2 | 0 copy, 1 transfer, 2 writeback add, 3 writeback subtract |
| outWord | output | 32 | Encoded word for copy and writeback |
| outIsLoad | output | 1 | Transfer direction (1 = load) |
| outReg | output | 4 | Transfer register index |
| outOffset | output | 32 | Signed transfer byte offset |
| outLast | output | 1 | Final descriptor of the stream |
| badMode | output | 1 | Unsupported mode seen |

## Verification
The bench walks all nine legal modes, crossed with register lists chosen to separate cases:
- empty list
- single lowest bit
- single highest bit
- full list
- sparse patterns

Across these, the condition and base-register fields change. The empty and single-bit lists isolate the last-flag placement and the 4n terms. The full and sparse lists expose ordering and stepping errors. Changing the pairs of U and P tells the four start-offset formulas apart, and the same pairs separate add from subtract in the writeback. Every instruction is replayed with a stalling ready pattern to check hold behaviour. A set of illegal modes then checks the error path.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    UOP_COPY  = 2'd0,
    UOP_XFER  = 2'd1,
    UOP_WBADD = 2'd2,
    UOP_WBSUB = 2'd3
  } uopKind_t;

  typedef struct packed {
    logic load;
    logic step;
  } ctrlStrobes_t;
endpackage

// File: rtl/lsm_datapath.sv
module lsm_datapath
  import lsm_pkg::*;
#(
  parameter int LIST_W = 16,
  parameter int WORD_W = 32,
  parameter int STEP   = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobes_t                strb,
  input  logic [WORD_W-1:0]           inWord,
  output logic                        modeOk,
  output logic                        listEmpty,
  output logic                        listOne,
  output logic                        wbEn,
  output logic                        upDir,
  output logic                        isLoad,
  output logic [$clog2(LIST_W)-1:0]   regIdx,
  output logic signed [WORD_W-1:0]    offset,
  output logic [WORD_W-1:0]           copyWord,
  output logic [WORD_W-1:0]           wbWord
);
  localparam int IDX_W = $clog2(LIST_W);
  localparam int CNT_W = $clog2(LIST_W + 1);

  logic [LIST_W-1:0]        remList;
  logic [CNT_W-1:0]         nQ;
  logic [3:0]               condQ;
  logic [3:0]               rnQ;
  logic [15:0]              upperLo;
  logic                     upQ, wbQ, ldQ;
  logic [CNT_W-1:0]         nIn;
  logic signed [WORD_W-1:0] nTimesStep, startOff;

  always_comb begin
    case (inWord[24:20])
      5'h01, 5'h03, 5'h08, 5'h09, 5'h0B, 5'h11, 5'h12, 5'h18, 5'h19: modeOk = 1'b1;
      default: modeOk = 1'b0;
    endcase
  end

  always_comb begin
    nIn = '0;
    for (int i = 0; i < LIST_W; i++) nIn = nIn + CNT_W'(inWord[i]);
  end

  always_comb begin
    nTimesStep = WORD_W'(nIn) * STEP;
    case ({inWord[24], inWord[23]})
      2'b00:   startOff = nTimesStep - STEP;
      2'b01:   startOff = '0;
      2'b10:   startOff = nTimesStep;
      default: startOff = STEP;
    endcase
  end

  always_comb begin
    regIdx = '0;
    for (int i = LIST_W - 1; i >= 0; i--)
      if (remList[i]) regIdx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remList <= '0;
      nQ      <= '0;
      condQ   <= '0;
      rnQ     <= '0;
      upperLo <= '0;
      upQ     <= 1'b0;
      wbQ     <= 1'b0;
      ldQ     <= 1'b0;
      offset  <= '0;
    end else if (strb.load) begin
      remList <= inWord[LIST_W-1:0];
      nQ      <= nIn;
      condQ   <= inWord[31:28];
      rnQ     <= inWord[19:16];
      upperLo <= inWord[31:16];
      upQ     <= inWord[23];
      wbQ     <= inWord[21];
      ldQ     <= inWord[20];
      offset  <= startOff;
    end else if (strb.step) begin
      remList <= remList & (remList - LIST_W'(1));
      offset  <= upQ ? offset + STEP : offset - STEP;
    end
  end

  assign listEmpty = (remList == '0);
  assign listOne   = !listEmpty && ((remList & (remList - LIST_W'(1))) == '0);
  assign wbEn      = wbQ;
  assign upDir     = upQ;
  assign isLoad    = ldQ;
  assign copyWord  = {upperLo, 16'h0000};
  assign wbWord    = {condQ, 28'h0} | 32'h0240_0000 | (WORD_W'(rnQ) << 16)
                   | (WORD_W'(rnQ) << 12) | (WORD_W'(nQ) * STEP);
endmodule

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
  import lsm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         outReady,
  input  logic         modeOk,
  input  logic         listEmpty,
  input  logic         listOne,
  input  logic         wbEn,
  input  logic         upDir,
  output ctrlStrobes_t strb,
  output logic         inReady,
  output logic         outValid,
  output uopKind_t     outKind,
  output logic         outLast,
  output logic         badMode
);
  typedef enum logic [1:0] {S_IDLE, S_COPY, S_XFER, S_WB} state_t;
  state_t state, nextState;
  logic accept, fire;

  assign inReady  = (state == S_IDLE);
  assign outValid = (state != S_IDLE);
  assign accept   = inValid && inReady;
  assign fire     = outValid && outReady;

  always_comb begin
    strb.load = accept && modeOk;
    strb.step = fire && (state == S_XFER);
  end

  always_comb begin
    nextState = state;
    case (state)
      S_IDLE: if (accept && modeOk) nextState = S_COPY;
      S_COPY: if (fire) nextState = !listEmpty ? S_XFER : (wbEn ? S_WB : S_IDLE);
      S_XFER: if (fire && listOne) nextState = wbEn ? S_WB : S_IDLE;
      default: if (fire) nextState = S_IDLE;
    endcase
  end

  always_comb begin
    case (state)
      S_XFER: begin
        outKind = UOP_XFER;
        outLast = listOne && !wbEn;
      end
      S_WB: begin
        outKind = upDir ? UOP_WBADD : UOP_WBSUB;
        outLast = 1'b1;
      end
      S_COPY: begin
        outKind = UOP_COPY;
        outLast = listEmpty && !wbEn;
      end
      default: begin
        outKind = UOP_COPY;
        outLast = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      badMode <= 1'b0;
    end else begin
      state   <= nextState;
      badMode <= accept && !modeOk;
    end
  end
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
  import lsm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] inWord,
  output logic        inReady,
  output logic        outValid,
  input  logic        outReady,
  output logic [1:0]  outKind,
  output logic [31:0] outWord,
  output logic        outIsLoad,
  output logic [3:0]  outReg,
  output logic [31:0] outOffset,
  output logic        outLast,
  output logic        badMode
);
  ctrlStrobes_t strb;
  uopKind_t kind;
  logic modeOk, listEmpty, listOne, wbEn, upDir;
  logic [31:0] copyWord, wbWord;
  logic signed [31:0] offset;

  lsm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .modeOk(modeOk), .listEmpty(listEmpty), .listOne(listOne), .wbEn(wbEn),
    .upDir(upDir), .strb(strb), .inReady(inReady), .outValid(outValid),
    .outKind(kind), .outLast(outLast), .badMode(badMode)
  );

  lsm_datapath #(.LIST_W(16), .WORD_W(32), .STEP(4)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inWord(inWord), .modeOk(modeOk),
    .listEmpty(listEmpty), .listOne(listOne), .wbEn(wbEn), .upDir(upDir),
    .isLoad(outIsLoad), .regIdx(outReg), .offset(offset),
    .copyWord(copyWord), .wbWord(wbWord)
  );

  assign outKind   = kind;
  assign outOffset = offset;
  assign outWord   = (kind == UOP_COPY) ? copyWord :
                     (kind == UOP_XFER) ? 32'h0 : wbWord;
endmodule

// File: rtl/lsm_uop_seq_chk.sv
module lsm_uop_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [1:0]  outKind,
  input logic [31:0] outWord,
  input logic [3:0]  outReg,
  input logic [31:0] outOffset,
  input logic        outLast,
  input logic        badMode
);
  // R1
  idle_only_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !outValid);
  // R2
  copy_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (badMode || (outValid && outKind == 2'd0)));
  // R6
  wb_is_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind[1]) |-> outLast);
  // R7
  last_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> !outValid);
  // R8
  bad_no_uop_chk: assert property (@(posedge clk) disable iff (!rstN)
    badMode |-> !outValid);
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outKind) && $stable(outWord)
      && $stable(outReg) && $stable(outOffset) && $stable(outLast)));
endmodule

bind lsm_uop_seq lsm_uop_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outKind(outKind),
  .outWord(outWord), .outReg(outReg), .outOffset(outOffset),
  .outLast(outLast), .badMode(badMode)
);

// File: tb/lsm_uop_seq_test.sv
module lsm_uop_seq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic outReady = 1'b0;
  logic inReady, outValid, outIsLoad, outLast, badMode;
  logic [1:0] outKind;
  logic [31:0] outWord, outOffset;
  logic [3:0] outReg;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lsm_uop_seq uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .inReady(inReady), .outValid(outValid), .outReady(outReady),
    .outKind(outKind), .outWord(outWord), .outIsLoad(outIsLoad),
    .outReg(outReg), .outOffset(outOffset), .outLast(outLast),
    .badMode(badMode)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runOne(input logic [31:0] w, input bit stall);
    int n, total, k, cyc, bitPos;
    logic [31:0] off, wbw;
    bit up, wb, pre, legal;
    logic [4:0] mode;
    mode = w[24:20];
    legal = (mode == 5'h01 || mode == 5'h03 || mode == 5'h08 || mode == 5'h09 ||
             mode == 5'h0B || mode == 5'h11 || mode == 5'h12 || mode == 5'h18 ||
             mode == 5'h19);
    n = 0;
    for (int i = 0; i < 16; i++) n += w[i];
    up = w[23]; wb = w[21]; pre = w[24];
    total = n + 1 + int'(wb);
    @(negedge clk);
    chk("R1", "inReady idle", 32'(inReady), 32'd1);
    inValid = 1'b1; inWord = w;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    if (!legal) begin
      chk("R8", "badMode", 32'(badMode), 32'd1);
      chk("R8", "no descriptor", 32'(outValid), 32'd0);
      @(negedge clk);
      chk("R8", "badMode drops", 32'(badMode), 32'd0);
      return;
    end
    // R4 start offsets
    if (!pre && !up) off = 32'(4 * n - 4);
    else if (!pre && up) off = 32'd0;
    else if (pre && !up) off = 32'(4 * n);
    else off = 32'd4;
    wbw = {w[31:28], 28'h0} | 32'h0240_0000 | (32'(w[19:16]) << 16)
        | (32'(w[19:16]) << 12) | 32'(4 * n);
    k = 0; cyc = 0; bitPos = 0;
    while (k < total) begin
      chk("R1", "outValid", 32'(outValid), 32'd1);
      if (k == 0) begin
        chk("R2", "copy kind", 32'(outKind), 32'd0);
        chk("R2", "copy word", outWord, {w[31:16], 16'h0});
        chk("R7", "copy last", 32'(outLast), 32'(n == 0 && !wb));
      end else if (k <= n) begin
        while (!w[bitPos]) bitPos++;
        chk("R3", "xfer kind", 32'(outKind), 32'd1);
        chk("R3", "xfer reg", 32'(outReg), 32'(bitPos));
        chk("R3", "xfer load", 32'(outIsLoad), 32'(w[20]));
        chk(k == 1 ? "R4" : "R5", "xfer offset", outOffset, off);
        chk("R7", "xfer last", 32'(outLast), 32'(k == n && !wb));
      end else begin
        chk("R6", "wb kind", 32'(outKind), up ? 32'd2 : 32'd3);
        chk("R6", "wb word", outWord, wbw);
        chk("R7", "wb last", 32'(outLast), 32'd1);
      end
      outReady = stall ? ((cyc % 3) != 1) : 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (outReady) begin
        if (k >= 1 && k <= n) begin
          bitPos++;
          off = up ? off + 32'd4 : off - 32'd4;
        end
        k++;
      end else begin
        chk("R9", "hold valid", 32'(outValid), 32'd1);
      end
      outReady = 1'b0;
      cyc++;
    end
    chk("R1", "stream ends", 32'(outValid), 32'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] modes [9] = '{5'h01, 5'h03, 5'h08, 5'h09, 5'h0B, 5'h11, 5'h12, 5'h18, 5'h19};
    logic [15:0] lists [6] = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF, 16'h00A5, 16'h5A30};
    logic [4:0] bads [5] = '{5'h00, 5'h02, 5'h0A, 5'h1F, 5'h13};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset outValid", 32'(outValid), 32'd0);
    chk("R1", "reset inReady", 32'(inReady), 32'd1);
    chk("R8", "reset badMode", 32'(badMode), 32'd0);
    rstN = 1'b1;
    for (int m = 0; m < 9; m++)
      for (int l = 0; l < 6; l++)
        for (int s = 0; s < 2; s++)
          runOne({4'(m + l), 3'b100, modes[m], 4'((m * 3 + l) % 16), lists[l]}, s != 0);
    for (int b = 0; b < 5; b++)
      runOne({4'hE, 3'b100, bads[b], 4'h3, 16'h00F0}, 1'b0);
    runOne({4'h1, 3'b100, 5'h0B, 4'hD, 16'h0C03}, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule